// File: doc/BRIEF.md
# Tile Background Pixel Renderer

This block turns a tile-based background description into a raster stream of 2-bit colour indices. It covers a 256 x 240 picture made of 32 x 30 cells, each 8 x 8 pixels. For each cell it reads one tile number from a tile-map (name grid) memory. It then reads the two bit-plane bytes of the current pixel line of that tile from pattern memory. The two planes are merged into one colour index per pixel. Alongside each pixel it gives x and y coordinates, a valid strobe and a frame-start marker.

The block drives two read ports. The memory behind each port returns data in the same cycle as the address. The block captures that data on the next clock edge. Fetches run one tile ahead of the pixel being output, so after the initial fill the stream runs at one pixel per clock with no gaps. Control inputs choose one of four name grids and one of two pattern tables. A background-enable input blanks the colour index without stopping the raster.

Top module: `bg_tile_raster`

## Requirements
- R1: While and just after reset, pix_valid, frame_start and pix_idx are all 0.
- R2: After reset is released, pix_valid rises on the 8th rising clock edge with pix_x = 0 and pix_y = 0. It then stays high every cycle. pix_x counts 0 to 255, and pix_y advances by one each time pix_x wraps, counting 0 to 239 and then returning to 0.
- R3: The name-grid read for cell column c and cell row r uses address 0x2000 + nt_sel*0x400 + r*32 + c.
- R4: For tile number t on pixel line y, the low-plane byte is read at pt_sel*0x1000 + t*16 + (y mod 8). The high-plane byte is read 8 bytes above it.
- R5: pix_idx bit 1 is taken from the high-plane byte and bit 0 from the low-plane byte, at the same bit position. The leftmost pixel of a cell uses bit 7 and each pixel to the right uses the next lower bit. For example, a low byte of 5 with a high byte of 7 gives indices 0,0,0,0,0,3,2,3.
- R6: When bg_en is low, pix_idx is 0 while pix_valid and the coordinates keep running unchanged.
- R7: frame_start is high for exactly one cycle, the cycle whose pixel is (0,0) following (255,239). It stays low for the first pixel after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bg_en | input | 1 | Background enable; low forces index 0 |
| nt_sel | input | 2 | Name grid select |
| pt_sel | input | 1 | Pattern table select |
| name_addr | output | 14 | Name grid read address |
| name_data | input | 8 | Tile number returned for name_addr |
| pat_addr | output | 14 | Pattern memory read address |
| pat_data | input | 8 | Byte returned for pat_addr |
| pix_valid | output | 1 | Pixel strobe |
| pix_x | output | 8 | Pixel column |
| pix_y | output | 8 | Pixel line |
| pix_idx | output | 2 | Colour index |
| frame_start | output | 1 | One-cycle marker on the first pixel of a new frame |

## Verification
Memory contents are generated arithmetically, so each cell holds a different tile and each tile line holds unrelated plane bytes. Every pixel index in a run can then be predicted on its own. Runs with different name-grid and pattern-table selections tell apart correct base arithmetic from a wrong stride or a swapped table. A run that crosses the line-8 boundary exposes fine-row and cell-row mistakes. A planted tile with plane bytes 5 and 7 at the origin separates swapped planes and reversed bit order. A full frame followed by the wrap checks the coordinate sequence and the frame marker, and a run with the background disabled shows that blanking does not disturb the raster.

// File: rtl/bgr_pkg.sv
package bgr_pkg;
   localparam int TILE_PX   = 8;
   localparam int PLANE_GAP = 8;
   localparam int TILE_BYTES = 16;
   localparam logic [2:0] PH_NAME = 3'd0;
   localparam logic [2:0] PH_LO   = 3'd1;
   localparam logic [2:0] PH_HI   = 3'd2;
   localparam logic [2:0] PH_LOAD = 3'd7;
endpackage

// File: rtl/bgr_raster_ctr.sv
module bgr_raster_ctr #(
   parameter int XW    = 8,
   parameter int YW    = 8,
   parameter int MAX_X = 255,
   parameter int MAX_Y = 239
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          en,
   output logic [XW-1:0] x,
   output logic [YW-1:0] y
);
   always_ff @(posedge clk) begin
      if (rst) begin
         x <= '0;
         y <= '0;
      end else if (en) begin
         if (x == XW'(MAX_X)) begin
            x <= '0;
            y <= (y == YW'(MAX_Y)) ? '0 : y + 1'b1;
         end else begin
            x <= x + 1'b1;
         end
      end
   end
endmodule

// File: rtl/bgr_fetch.sv
module bgr_fetch
   import bgr_pkg::*;
#(
   parameter int ADDR_W    = 14,
   parameter int CW        = 5,
   parameter int RW        = 5,
   parameter int TILE_COLS = 32,
   parameter int NT_BASE   = 'h2000,
   parameter int NT_STRIDE = 'h400,
   parameter int PT_STRIDE = 'h1000
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [2:0]        phase,
   input  logic [CW-1:0]     col,
   input  logic [RW-1:0]     row,
   input  logic [2:0]        fine,
   input  logic [1:0]        nt_sel,
   input  logic              pt_sel,
   output logic [ADDR_W-1:0] name_addr,
   input  logic [7:0]        name_data,
   output logic [ADDR_W-1:0] pat_addr,
   input  logic [7:0]        pat_data,
   output logic [7:0]        lo_q,
   output logic [7:0]        hi_q
);
   logic [7:0] tile_q;

   assign name_addr = ADDR_W'(NT_BASE) + ADDR_W'(nt_sel) * ADDR_W'(NT_STRIDE)
                    + ADDR_W'(row) * ADDR_W'(TILE_COLS) + ADDR_W'(col);

   assign pat_addr = ADDR_W'(pt_sel) * ADDR_W'(PT_STRIDE)
                   + ADDR_W'(tile_q) * ADDR_W'(TILE_BYTES)
                   + ADDR_W'(fine)
                   + ((phase == PH_HI) ? ADDR_W'(PLANE_GAP) : '0);

   always_ff @(posedge clk) begin
      if (rst) begin
         tile_q <= '0;
         lo_q   <= '0;
         hi_q   <= '0;
      end else begin
         if (phase == PH_NAME) tile_q <= name_data;
         if (phase == PH_LO)   lo_q   <= pat_data;
         if (phase == PH_HI)   hi_q   <= pat_data;
      end
   end
endmodule

// File: rtl/bgr_shift.sv
module bgr_shift #(
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       load,
   input  logic [7:0] lo_in,
   input  logic [7:0] hi_in,
   output logic [1:0] pix
);
   logic [7:0] sh_lo, sh_hi;

   generate
      if (MSB_FIRST) begin : g_msb
         always_ff @(posedge clk) begin
            if (rst) begin
               sh_lo <= '0;
               sh_hi <= '0;
            end else if (load) begin
               sh_lo <= lo_in;
               sh_hi <= hi_in;
            end else begin
               sh_lo <= {sh_lo[6:0], 1'b0};
               sh_hi <= {sh_hi[6:0], 1'b0};
            end
         end
         assign pix = {sh_hi[7], sh_lo[7]};
      end else begin : g_lsb
         always_ff @(posedge clk) begin
            if (rst) begin
               sh_lo <= '0;
               sh_hi <= '0;
            end else if (load) begin
               sh_lo <= lo_in;
               sh_hi <= hi_in;
            end else begin
               sh_lo <= {1'b0, sh_lo[7:1]};
               sh_hi <= {1'b0, sh_hi[7:1]};
            end
         end
         assign pix = {sh_hi[0], sh_lo[0]};
      end
   endgenerate
endmodule

// File: rtl/bg_tile_raster.sv
module bg_tile_raster
   import bgr_pkg::*;
#(
   parameter int TILE_COLS = 32,
   parameter int TILE_ROWS = 30,
   parameter int ADDR_W    = 14,
   parameter int NT_BASE   = 'h2000,
   parameter int NT_STRIDE = 'h400,
   parameter int PT_STRIDE = 'h1000,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              bg_en,
   input  logic [1:0]        nt_sel,
   input  logic              pt_sel,
   output logic [ADDR_W-1:0] name_addr,
   input  logic [7:0]        name_data,
   output logic [ADDR_W-1:0] pat_addr,
   input  logic [7:0]        pat_data,
   output logic              pix_valid,
   output logic [$clog2(TILE_COLS*TILE_PX)-1:0] pix_x,
   output logic [$clog2(TILE_ROWS*TILE_PX)-1:0] pix_y,
   output logic [1:0]        pix_idx,
   output logic              frame_start
);
   localparam int W_PX = TILE_COLS * TILE_PX;
   localparam int H_PX = TILE_ROWS * TILE_PX;
   localparam int XW   = $clog2(W_PX);
   localparam int YW   = $clog2(H_PX);
   localparam int CW   = XW - 3;
   localparam int RW   = YW - 3;

   generate
      if (ADDR_W < 14)
         $error("bg_tile_raster: ADDR_W too small for the name grid window");
      if (TILE_COLS * TILE_ROWS > NT_STRIDE)
         $error("bg_tile_raster: name grid does not fit in one stride");
      if (PT_STRIDE < 256 * TILE_BYTES)
         $error("bg_tile_raster: pattern table stride too small");
      if ((1 << XW) != W_PX)
         $error("bg_tile_raster: TILE_COLS must be a power of two");
   endgenerate

   logic [XW-1:0] fx, ox;
   logic [YW-1:0] fy, oy;
   logic          primed;
   logic [7:0]    lo_q, hi_q;
   logic [1:0]    sh_pix;
   logic          load;

   bgr_raster_ctr #(.XW(XW), .YW(YW), .MAX_X(W_PX-1), .MAX_Y(H_PX-1)) u_fetch_ctr (
      .clk(clk), .rst(rst), .en(1'b1), .x(fx), .y(fy)
   );

   bgr_raster_ctr #(.XW(XW), .YW(YW), .MAX_X(W_PX-1), .MAX_Y(H_PX-1)) u_out_ctr (
      .clk(clk), .rst(rst), .en(primed), .x(ox), .y(oy)
   );

   bgr_fetch #(
      .ADDR_W(ADDR_W), .CW(CW), .RW(RW), .TILE_COLS(TILE_COLS),
      .NT_BASE(NT_BASE), .NT_STRIDE(NT_STRIDE), .PT_STRIDE(PT_STRIDE)
   ) u_fetch (
      .clk(clk), .rst(rst), .phase(fx[2:0]), .col(fx[XW-1:3]), .row(fy[YW-1:3]),
      .fine(fy[2:0]), .nt_sel(nt_sel), .pt_sel(pt_sel),
      .name_addr(name_addr), .name_data(name_data),
      .pat_addr(pat_addr), .pat_data(pat_data),
      .lo_q(lo_q), .hi_q(hi_q)
   );

   assign load = (fx[2:0] == PH_LOAD);

   bgr_shift #(.MSB_FIRST(MSB_FIRST)) u_shift (
      .clk(clk), .rst(rst), .load(load), .lo_in(lo_q), .hi_in(hi_q), .pix(sh_pix)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         primed      <= 1'b0;
         frame_start <= 1'b0;
      end else begin
         primed      <= primed | load;
         frame_start <= primed && (ox == XW'(W_PX-1)) && (oy == YW'(H_PX-1));
      end
   end

   assign pix_valid = primed;
   assign pix_x     = ox;
   assign pix_y     = oy;
   assign pix_idx   = (bg_en && primed) ? sh_pix : 2'b00;
endmodule

// File: rtl/bgr_chk.sv
module bgr_chk #(
   parameter int TILE_COLS = 32,
   parameter int TILE_ROWS = 30,
   parameter int ADDR_W    = 14,
   parameter int NT_BASE   = 'h2000,
   parameter int NT_STRIDE = 'h400,
   parameter int XW        = 8,
   parameter int YW        = 8
) (
   input logic              clk,
   input logic              rst,
   input logic [1:0]        nt_sel,
   input logic [ADDR_W-1:0] name_addr,
   input logic              pix_valid,
   input logic [XW-1:0]     pix_x,
   input logic [YW-1:0]     pix_y,
   input logic              frame_start
);
   localparam int LAST_X = TILE_COLS * 8 - 1;
   localparam int LAST_Y = TILE_ROWS * 8 - 1;
   int base_i;
   assign base_i = NT_BASE + int'(nt_sel) * NT_STRIDE;

   assert_valid_holds_R2: assert property (@(posedge clk) disable iff (rst)
      pix_valid |=> pix_valid);

   assert_x_steps_R2: assert property (@(posedge clk) disable iff (rst)
      (pix_valid && pix_x != XW'(LAST_X)) |=> (pix_x == $past(pix_x) + 1'b1));

   assert_y_steps_R2: assert property (@(posedge clk) disable iff (rst)
      (pix_valid && pix_x == XW'(LAST_X) && pix_y != YW'(LAST_Y))
      |=> (pix_x == '0 && pix_y == $past(pix_y) + 1'b1));

   assert_name_window_R3: assert property (@(posedge clk) disable iff (rst)
      (int'(name_addr) >= base_i) && (int'(name_addr) < base_i + TILE_COLS * TILE_ROWS));

   assert_mark_at_origin_R7: assert property (@(posedge clk) disable iff (rst)
      frame_start |-> (pix_valid && pix_x == '0 && pix_y == '0));

   assert_mark_single_R7: assert property (@(posedge clk) disable iff (rst)
      frame_start |=> !frame_start);
endmodule

bind bg_tile_raster bgr_chk #(
   .TILE_COLS(TILE_COLS), .TILE_ROWS(TILE_ROWS), .ADDR_W(ADDR_W),
   .NT_BASE(NT_BASE), .NT_STRIDE(NT_STRIDE), .XW(XW), .YW(YW)
) u_bgr_chk (
   .clk(clk), .rst(rst), .nt_sel(nt_sel), .name_addr(name_addr),
   .pix_valid(pix_valid), .pix_x(pix_x), .pix_y(pix_y), .frame_start(frame_start)
);

// File: tb/tb_bg_tile_raster.sv
module tb_bg_tile_raster;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        bg_en = 1'b1;
   logic [1:0]  nt_sel = 2'd0;
   logic        pt_sel = 1'b0;
   logic [13:0] name_addr, pat_addr;
   logic [7:0]  name_data, pat_data;
   logic        pix_valid, frame_start;
   logic [7:0]  pix_x, pix_y;
   logic [1:0]  pix_idx;

   int n_chk = 0;
   int n_bad = 0;

   initial forever #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [7:0] nt_fn(input int a);
      return 8'(a * 7 + (a >> 5) * 3);
   endfunction

   function automatic logic [7:0] pat_fn(input int a);
      if (a == 0) return 8'd5;
      if (a == 8) return 8'd7;
      return 8'(a * 37 + (a >> 4) * 11 + 3);
   endfunction

   assign name_data = nt_fn(int'(name_addr));
   assign pat_data  = pat_fn(int'(pat_addr));

   bg_tile_raster dut (
      .clk(clk), .rst(rst), .bg_en(bg_en), .nt_sel(nt_sel), .pt_sel(pt_sel),
      .name_addr(name_addr), .name_data(name_data),
      .pat_addr(pat_addr), .pat_data(pat_data),
      .pix_valid(pix_valid), .pix_x(pix_x), .pix_y(pix_y),
      .pix_idx(pix_idx), .frame_start(frame_start)
   );

   // R3/R4/R5/R6 reference: index for pixel (x, y)
   function automatic int ref_idx(input int nt, input int pt, input bit en,
                                  input int x, input int y);
      int t, pb, b;
      logic [7:0] lo, hi;
      if (!en) return 0;
      t  = nt_fn('h2000 + nt * 'h400 + (y / 8) * 32 + (x / 8));
      pb = pt * 'h1000 + t * 16 + (y % 8);
      lo = pat_fn(pb);
      hi = pat_fn(pb + 8);
      b  = 7 - (x % 8);
      return {hi[b], lo[b]};
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   // Reset with the given controls, then count edges until the first pixel (R2).
   task automatic start(input int nt, input int pt, input bit en);
      int edges;
      @(negedge clk);
      rst = 1'b1; nt_sel = 2'(nt); pt_sel = 1'(pt); bg_en = en;
      repeat (3) @(negedge clk);
      check(pix_valid == 1'b0, "R1", "valid in reset", pix_valid, 0);
      check(frame_start == 1'b0, "R1", "mark in reset", frame_start, 0);
      check(pix_idx == 2'd0, "R1", "index in reset", pix_idx, 0);
      rst = 1'b0;
      edges = 0;
      for (int k = 0; k < 20; k++) begin
         @(negedge clk);
         edges++;
         if (pix_valid) break;
      end
      check(edges == 8, "R2", "edges to first pixel", edges, 8);
   endtask

   // Compare a run of pixels starting at (0,0); current negedge is pixel 0.
   task automatic run_pixels(input int nt, input int pt, input bit en, input int npx);
      for (int n = 0; n < npx; n++) begin
         int ex, ey, ei;
         if (n > 0) @(negedge clk);
         ex = n % 256; ey = n / 256;
         ei = ref_idx(nt, pt, en, ex, ey);
         check(pix_valid == 1'b1, "R2", "valid", pix_valid, 1);
         check(int'(pix_x) == ex, "R2", "x", pix_x, ex);
         check(int'(pix_y) == ey, "R2", "y", pix_y, ey);
         check(int'(pix_idx) == ei, en ? "R5" : "R6", "index", pix_idx, ei);
         check(frame_start == 1'b0, "R7", "mark inside frame", frame_start, 0);
      end
   endtask

   // nt[15:14] pt[13] en[12] lines[11:0]
   localparam logic [15:0] VEC [4] = '{
      {2'd2, 1'b1, 1'b1, 12'd4},
      {2'd1, 1'b0, 1'b1, 12'd9},
      {2'd3, 1'b1, 1'b0, 12'd2},
      {2'd3, 1'b0, 1'b1, 12'd3}
   };

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL R2 watchdog: actual=running expected=finished");
      summary();
      $finish;
   end

   initial begin
      // Vector walk: R3, R4 via different bases, R6 blanking, R2 line-8 crossing
      for (int v = 0; v < 4; v++) begin
         int nt, pt, ln;
         bit en;
         nt = int'(VEC[v][15:14]); pt = int'(VEC[v][13]);
         en = VEC[v][12]; ln = int'(VEC[v][11:0]);
         start(nt, pt, en);
         run_pixels(nt, pt, en, ln * 256);
      end

      // Directed: R5 planted bytes 5 (low) and 7 (high) at tile 0 of grid 0
      start(0, 0, 1'b1);
      begin
         int exp5 [8] = '{0, 0, 0, 0, 0, 3, 2, 3};
         for (int i = 0; i < 8; i++) begin
            if (i > 0) @(negedge clk);
            check(int'(pix_idx) == exp5[i], "R5", "planted row pixel", pix_idx, exp5[i]);
         end
      end

      // Directed: full frame then wrap (R2, R7)
      start(0, 0, 1'b1);
      run_pixels(0, 0, 1'b1, 256 * 240);
      @(negedge clk);
      check(frame_start == 1'b1, "R7", "mark on wrap", frame_start, 1);
      check(pix_x == 8'd0 && pix_y == 8'd0, "R7", "wrap coordinates",
            int'(pix_x) + 256 * int'(pix_y), 0);
      check(int'(pix_idx) == ref_idx(0, 0, 1'b1, 0, 0), "R5", "wrap pixel index",
            pix_idx, ref_idx(0, 0, 1'b1, 0, 0));
      @(negedge clk);
      check(frame_start == 1'b0, "R7", "mark one cycle", frame_start, 0);
      check(pix_x == 8'd1, "R2", "x after wrap", pix_x, 1);

      // Directed: disable mid-stream, raster keeps running (R6)
      bg_en = 1'b0;
      @(negedge clk);
      check(pix_idx == 2'd0, "R6", "index blanked", pix_idx, 0);
      check(pix_valid == 1'b1 && pix_x == 8'd2, "R6", "raster continues", pix_x, 2);

      summary();
      $finish;
   end
endmodule